// File: doc/BRIEF.md
# Non-Linear Ratio External Clock Divider

This block divides a fast base clock (a 96 MHz reference in the intended system) down to a slower external master or bit clock. A 16-bit control word carries a 6-bit ratio code. The code does not map linearly onto the divisor. Small codes step the divisor by one, from 2 up to 8. Larger codes step it by two, from 10 up to 96. Odd divisors above 8 therefore cannot be selected. The divided clock leaves the block as a level `clk_out`, high for the lower half of each period, together with a one-cycle `period_end` strobe that marks the last base cycle of each period.

A second write port accepts a requested minimum divisor. The built-in encoder rounds that request up to the nearest legal divisor and saturates at 96. It then writes the matching ratio code into the control word. The same write clears the base-select bit and leaves every other bit of the word untouched. A new ratio never cuts a period short: it takes effect only at the next period boundary. Setting the base-select bit parks the divider with its outputs low.

Top module: `ext_clk_div`

## Requirements
- R1: Ratio codes 0 to 6 (field at control bits 7:2) select divisor code+2: code 0 gives 2, code 1 gives 3, code 5 gives 7, code 6 gives 8.
- R2: Ratio codes 7 to 50 select divisor 8+2*(code-6): code 7 gives 10, code 8 gives 12, code 20 gives 36, code 49 gives 94, code 50 gives 96.
- R3: Ratio codes 51 to 63 select divisor 96.
- R4: While running with divisor d, each period lasts d base cycles. `clk_out` is high for the first floor(d/2) cycles of the period. `period_end` is high only in the last cycle.
- R5: A ratio change written in the middle of a period does not alter that period. The new divisor governs the periods that start after the next `period_end`.
- R6: While control bit 0 is 1, `clk_out` and `period_end` stay low. When the bit returns to 0, the divider starts a fresh period in the following cycle, using the divisor currently held in the field.
- R7: A request write with value t stores the code of the smallest legal divisor that is at least t. Requests of 2 or less give code 0. Requests of 95 or more give code 50. Example: t=9 and t=10 give code 7, and t=11 gives code 8.
- R8: A request write replaces bits 7:2 with the encoded code and clears bit 0. It keeps bit 1 and bits 15:8. The result is visible on `ctrl_q` in the cycle after the write.
- R9: When a full control write and a request write arrive in the same cycle, the full write wins, and `ctrl_q` then equals `cfg_wdata`.
- R10: After reset, `ctrl_q` is 0x0000, the active divisor is 2, and the divider is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock that is divided |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Full control word write strobe |
| cfg_wdata | input | 16 | Control word value for a full write |
| req_we | input | 1 | Requested-divisor write strobe |
| req_div | input | 7 | Requested minimum divisor |
| ctrl_q | output | 16 | Current control word |
| clk_out | output | 1 | Divided clock level |
| period_end | output | 1 | High in the last base cycle of each output period |

## Verification
The bench builds the block with its default parameters: a 16-bit control word, the ratio field at bits 7:2, and a divisor span of 2 to 96. These values bring every branch of the piecewise map within reach. That covers the linear step zone, the first even divisor after it, the saturated top end, and codes beyond the last legal one. Each table vector sends a request through the encoder, reads back the stored code, and then measures two full output periods of the divisor that code selects. A directed case changes the ratio mid-period to show that the period boundary holds.

// File: rtl/ecd_pkg.sv
package ecd_pkg;
  localparam int DIV_W       = 7;
  localparam int CODE_W      = 6;
  localparam int MIN_DIV     = 2;
  localparam int LIN_MAX_DIV = 8;
  localparam int MAX_DIV     = 96;
  localparam int LIN_CODES   = LIN_MAX_DIV - MIN_DIV;
  localparam int MAX_CODE    = LIN_CODES + (MAX_DIV - LIN_MAX_DIV) / 2;
  localparam int STEP_OFS    = LIN_CODES - LIN_MAX_DIV / 2;

  typedef logic [DIV_W-1:0]  ecd_div_t;
  typedef logic [CODE_W-1:0] ecd_code_t;

  // Ratio code to divisor, piecewise: unit steps, then steps of two, then clamp.
  function automatic ecd_div_t ratio_to_div(input ecd_code_t c);
    int ci;
    int d;
    ci = int'(c);
    if (ci <= LIN_CODES)     d = ci + MIN_DIV;
    else if (ci >= MAX_CODE) d = MAX_DIV;
    else                     d = LIN_MAX_DIV + 2 * (ci - LIN_CODES);
    return ecd_div_t'(d);
  endfunction

  // Smallest legal divisor not below the request, returned as its code.
  function automatic ecd_code_t div_to_ratio(input ecd_div_t t);
    int ti;
    int c;
    ti = int'(t);
    if (ti <= MIN_DIV)          c = 0;
    else if (ti <= LIN_MAX_DIV) c = ti - MIN_DIV;
    else if (ti >= MAX_DIV - 1) c = MAX_CODE;
    else                        c = (ti + 1) / 2 + STEP_OFS;
    return ecd_code_t'(c);
  endfunction
endpackage

// File: rtl/ecd_encoder.sv
module ecd_encoder
  import ecd_pkg::*;
(
  input  logic [DIV_W-1:0]  req_div,
  output logic [CODE_W-1:0] req_code
);
  always_comb req_code = div_to_ratio(req_div);
endmodule

// File: rtl/ecd_ctrl_reg.sv
module ecd_ctrl_reg
  import ecd_pkg::*;
#(
  parameter int REG_W     = 16,
  parameter int FIELD_LSB = 2,
  parameter int HALT_BIT  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [REG_W-1:0]  cfg_wdata,
  input  logic              req_we,
  input  logic [CODE_W-1:0] req_code,
  output logic [REG_W-1:0]  ctrl_q
);
  localparam int FIELD_MSB = FIELD_LSB + CODE_W - 1;

  logic [REG_W-1:0] merged;

  // Per-bit merge for a request write: field takes the code, halt bit clears,
  // every other bit keeps its value.
  for (genvar b = 0; b < REG_W; b++) begin : g_merge
    if (b >= FIELD_LSB && b <= FIELD_MSB) begin : g_field
      assign merged[b] = req_code[b - FIELD_LSB];
    end else if (b == HALT_BIT) begin : g_halt
      assign merged[b] = 1'b0;
    end else begin : g_keep
      assign merged[b] = ctrl_q[b];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      ctrl_q <= '0;
    else if (cfg_we) ctrl_q <= cfg_wdata;
    else if (req_we) ctrl_q <= merged;
  end
endmodule

// File: rtl/ecd_divcore.sv
module ecd_divcore
  import ecd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             halt,
  input  logic [DIV_W-1:0] target_div,
  output logic [DIV_W-1:0] active_div,
  output logic             clk_out,
  output logic             period_end
);
  logic [DIV_W-1:0] cnt;
  logic             wrap;

  assign wrap       = (cnt == active_div - DIV_W'(1));
  assign period_end = !halt && wrap;
  assign clk_out    = !halt && (cnt < (active_div >> 1));

  // The divisor is only reloaded at a period boundary or while parked.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt        <= '0;
      active_div <= DIV_W'(MIN_DIV);
    end else if (halt || wrap) begin
      cnt        <= '0;
      active_div <= target_div;
    end else begin
      cnt        <= cnt + DIV_W'(1);
    end
  end
endmodule

// File: rtl/ext_clk_div.sv
module ext_clk_div
  import ecd_pkg::*;
#(
  parameter int REG_W     = 16,
  parameter int FIELD_LSB = 2,
  parameter int HALT_BIT  = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [REG_W-1:0] cfg_wdata,
  input  logic             req_we,
  input  logic [DIV_W-1:0] req_div,
  output logic [REG_W-1:0] ctrl_q,
  output logic             clk_out,
  output logic             period_end
);
  logic [CODE_W-1:0] req_code;
  logic [CODE_W-1:0] field_code;
  logic [DIV_W-1:0]  target_div;
  logic [DIV_W-1:0]  active_div;
  logic              halt;

  ecd_encoder u_enc (
    .req_div (req_div),
    .req_code(req_code)
  );

  ecd_ctrl_reg #(
    .REG_W    (REG_W),
    .FIELD_LSB(FIELD_LSB),
    .HALT_BIT (HALT_BIT)
  ) u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_wdata(cfg_wdata),
    .req_we   (req_we),
    .req_code (req_code),
    .ctrl_q   (ctrl_q)
  );

  assign field_code = ctrl_q[FIELD_LSB +: CODE_W];
  assign target_div = ratio_to_div(field_code);
  assign halt       = ctrl_q[HALT_BIT];

  ecd_divcore u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .halt      (halt),
    .target_div(target_div),
    .active_div(active_div),
    .clk_out   (clk_out),
    .period_end(period_end)
  );
endmodule

// File: rtl/ext_clk_div_chk.sv
module ext_clk_div_chk
  import ecd_pkg::*;
#(
  parameter int REG_W     = 16,
  parameter int FIELD_LSB = 2,
  parameter int HALT_BIT  = 0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [REG_W-1:0] cfg_wdata,
  input logic             req_we,
  input logic [REG_W-1:0] ctrl_q,
  input logic             clk_out,
  input logic             period_end,
  input logic [DIV_W-1:0] active_div
);
  localparam int TOP_LSB = FIELD_LSB + CODE_W;

  logic [DIV_W-1:0] len_cnt;
  logic [DIV_W-1:0] hi_cnt;
  logic             parked;

  assign parked = ctrl_q[HALT_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n || parked || period_end) begin
      len_cnt <= '0;
      hi_cnt  <= '0;
    end else begin
      len_cnt <= len_cnt + DIV_W'(1);
      hi_cnt  <= hi_cnt + DIV_W'(clk_out);
    end
  end

  // R4: period length matches the active divisor
  p_period_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |-> (len_cnt == active_div - DIV_W'(1)));

  // R4: high time is floor(d/2)
  p_duty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |-> (hi_cnt == (active_div >> 1)));

  // R5: divisor is held steady inside a period
  p_no_runt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!period_end && !parked) |=> $stable(active_div));

  // R6: parked divider is silent
  p_parked_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    parked |-> (!clk_out && !period_end));

  // R2: only legal divisors ever become active
  p_legal_div_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (active_div >= DIV_W'(MIN_DIV)) && (active_div <= DIV_W'(MAX_DIV)) &&
    ((active_div <= DIV_W'(LIN_MAX_DIV)) || !active_div[0]));

  // R8: request write clears halt, keeps bit 1 and the upper byte
  p_req_merge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_we && !cfg_we) |=> (!ctrl_q[HALT_BIT] &&
      (ctrl_q[1] == $past(ctrl_q[1])) &&
      (ctrl_q[REG_W-1:TOP_LSB] == $past(ctrl_q[REG_W-1:TOP_LSB]))));

  // R9: full write has priority
  p_cfg_prio_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (ctrl_q == $past(cfg_wdata)));
endmodule

bind ext_clk_div ext_clk_div_chk #(
  .REG_W    (REG_W),
  .FIELD_LSB(FIELD_LSB),
  .HALT_BIT (HALT_BIT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .cfg_wdata (cfg_wdata),
  .req_we    (req_we),
  .ctrl_q    (ctrl_q),
  .clk_out   (clk_out),
  .period_end(period_end),
  .active_div(active_div)
);

// File: tb/ext_clk_div_tb.sv
module ext_clk_div_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 11;

  typedef struct packed {
    logic [6:0] t;
    logic [5:0] code;
    logic [6:0] d;
  } vec_t;

  // request -> expected stored code -> expected divisor
  localparam vec_t VECS [NV] = '{
    '{7'd0,   6'd0,  7'd2},   // R7 below minimum, R1
    '{7'd3,   6'd1,  7'd3},   // R1
    '{7'd7,   6'd5,  7'd7},   // R1
    '{7'd8,   6'd6,  7'd8},   // R1 last unit step
    '{7'd9,   6'd7,  7'd10},  // R7 odd rounds up, R2
    '{7'd10,  6'd7,  7'd10},  // R2
    '{7'd11,  6'd8,  7'd12},  // R2
    '{7'd36,  6'd20, 7'd36},  // R2
    '{7'd93,  6'd49, 7'd94},  // R2
    '{7'd95,  6'd50, 7'd96},  // R7 saturate, R2
    '{7'd127, 6'd50, 7'd96}   // R7 saturate
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic        req_we = 1'b0;
  logic [6:0]  req_div = '0;
  logic [15:0] ctrl_q;
  logic        clk_out;
  logic        period_end;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ext_clk_div u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .req_we(req_we), .req_div(req_div), .ctrl_q(ctrl_q),
    .clk_out(clk_out), .period_end(period_end)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Park with value v, then release; returns at the negedge of cycle 0.
  task automatic start_run(input logic [15:0] v);
    cfg_we = 1'b1; cfg_wdata = v | 16'h0001;
    @(negedge clk);
    cfg_wdata = v & 16'hfffe;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Watch two periods of divisor d starting at cycle 0.
  task automatic measure(input int d, input string req);
    int bad_i;
    int act_v;
    int exp_v;
    bad_i = -1; act_v = 0; exp_v = 0;
    for (int i = 0; i < 2 * d; i++) begin
      int ph;
      logic eo;
      logic ep;
      ph = i % d;
      eo = (ph < d / 2);
      ep = (ph == d - 1);
      if (bad_i < 0 && (clk_out !== eo || period_end !== ep)) begin
        bad_i = i; act_v = {clk_out, period_end}; exp_v = {eo, ep};
      end
      @(negedge clk);
    end
    chk(bad_i < 0, req, act_v, exp_v);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(ctrl_q == 16'h0000, "R10 ctrl reset", ctrl_q, 0);
    rst_n = 1'b1;
    // R10/R4: divide-by-2 running straight out of reset
    chk(clk_out == 1'b1 && period_end == 1'b0, "R10 first cycle", {clk_out, period_end}, 2);
    @(negedge clk);
    chk(clk_out == 1'b0 && period_end == 1'b1, "R10 second cycle", {clk_out, period_end}, 1);
    @(negedge clk);

    // Table: encode request, read code, then measure the divisor (R1 R2 R4 R7 R8)
    for (int k = 0; k < NV; k++) begin
      logic [15:0] expw;
      cfg_we = 1'b1; cfg_wdata = 16'hA503;
      @(negedge clk);
      cfg_we = 1'b0; req_we = 1'b1; req_div = VECS[k].t;
      @(negedge clk);
      req_we = 1'b0;
      expw = 16'hA502 | (16'(VECS[k].code) << 2);
      chk(ctrl_q == expw, "R7 R8 encoded word", ctrl_q, expw);
      start_run(ctrl_q);
      measure(int'(VECS[k].d), "R1 R2 R4 period shape");
    end

    // R3: code beyond the last legal one clamps to 96
    start_run(16'(63) << 2);
    measure(96, "R3 code 63");

    // R5: mid-period change to code 0 waits for the boundary
    begin
      int bad_i;
      int act_v;
      int exp_v;
      bad_i = -1; act_v = 0; exp_v = 0;
      start_run(16'(6) << 2);
      for (int i = 0; i < 12; i++) begin
        logic eo;
        logic ep;
        if (i < 8) begin
          eo = (i < 4); ep = (i == 7);
        end else begin
          eo = ((i - 8) % 2 == 0); ep = ((i - 8) % 2 == 1);
        end
        if (bad_i < 0 && (clk_out !== eo || period_end !== ep)) begin
          bad_i = i; act_v = {clk_out, period_end}; exp_v = {eo, ep};
        end
        if (i == 3) begin
          cfg_we = 1'b1; cfg_wdata = 16'h0000;
        end else begin
          cfg_we = 1'b0;
        end
        @(negedge clk);
      end
      chk(bad_i < 0, "R5 boundary hold", act_v, exp_v);
    end

    // R6: parked divider stays silent
    begin
      int seen;
      seen = 0;
      cfg_we = 1'b1; cfg_wdata = 16'h0015;
      @(negedge clk);
      cfg_we = 1'b0;
      for (int i = 0; i < 16; i++) begin
        if (clk_out || period_end) seen++;
        @(negedge clk);
      end
      chk(seen == 0, "R6 parked outputs", seen, 0);
    end
    // R6: release starts a fresh period with the held code (5 -> divisor 7)
    cfg_we = 1'b1; cfg_wdata = 16'h0014;
    @(negedge clk);
    cfg_we = 1'b0;
    measure(7, "R6 restart");

    // R9: full write beats a request in the same cycle
    cfg_we = 1'b1; cfg_wdata = 16'h1235; req_we = 1'b1; req_div = 7'd50;
    @(negedge clk);
    cfg_we = 1'b0; req_we = 1'b0;
    chk(ctrl_q == 16'h1235, "R9 write priority", ctrl_q, 16'h1235);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule